// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one integer-mode PLL when a command arrives, and keeps the clock consumer safe while it does so. A command is a start strobe plus four values: the reference divider, the feedback divider and two post-dividers. The block first checks that the requested VCO and output frequencies are inside the legal window. If the command is legal, the consumer is parked on the crystal bypass. The PLL is then put in integer mode and powered down, and the new dividers are written as two control words. Power is restored, and the block waits for lock before it returns the consumer to the PLL output.

Lock is polled once every `POLL_CYCLES` clocks. The status input reads 1 while the PLL is still settling. If the PLL has not locked after `LOCK_POLLS` polls, the sequence is abandoned, the consumer stays on the bypass, and an error pulse is raised. A command that fails the range check is refused outright. The analog PLL and any register interface sit outside this block.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, mode_norm=0, pll_pwrdn=1, pll_intmode=0, all four divider outputs are 0, and busy, done, range_err and lock_err are 0.
- R2: A command is legal if and only if refdiv, pd1 and pd2 are all nonzero and REF_MHZ*fb lies in [VCO_MIN_MHZ*ref, VCO_MAX_MHZ*ref] and in [OUT_MIN_MHZ*ref*pd1*pd2, OUT_MAX_MHZ*ref*pd1*pd2]. With the defaults this is a 24 MHz reference, a VCO window of 800 to 3200 MHz, and an output window of 24 to 3200 MHz, all bounds inclusive.
- R3: When start is sampled while idle with an illegal command, range_err is high for exactly the next cycle, busy stays 0, and every other output keeps its value.
- R4: A legal start sampled at clock edge 1 gives this order: at edge 1, mode_norm=0 and busy=1. At edge 2, pll_intmode=1. At edge 3, pll_pwrdn=1. At edge 4, pll_pd1 and pll_fbdiv take the new values. At edge 5, pll_pd2 and pll_refdiv take the new values. At edge 6, pll_pwrdn=0.
- R5: After power-up, lock_n is sampled at edges 6+k*POLL_CYCLES for k=1,2,... Only these samples count, and a value of 1 means the PLL is not yet locked.
- R6: At the first poll that sees lock_n=0, mode_norm becomes 1 and busy becomes 0, and done is high for exactly one cycle.
- R7: If the poll k=LOCK_POLLS still sees lock_n=1, then lock_err is high for exactly one cycle at edge 6+LOCK_POLLS*POLL_CYCLES, busy becomes 0, and mode_norm stays 0.
- R8: A start pulse while busy is ignored: the sequence completes with the first command's divider values.
- R9: The divider outputs change only while pll_pwrdn=1, pll_intmode=1 and mode_norm=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe |
| cfg_refdiv | input | REFDIV_W | Requested reference divider |
| cfg_fbdiv | input | FBDIV_W | Requested feedback divider |
| cfg_pd1 | input | PDIV_W | Requested first post-divider |
| cfg_pd2 | input | PDIV_W | Requested second post-divider |
| lock_n | input | 1 | PLL lock status, 1 = not yet locked |
| pll_refdiv | output | REFDIV_W | Reference divider field to the PLL |
| pll_fbdiv | output | FBDIV_W | Feedback divider field to the PLL |
| pll_pd1 | output | PDIV_W | First post-divider field to the PLL |
| pll_pd2 | output | PDIV_W | Second post-divider field to the PLL |
| pll_pwrdn | output | 1 | PLL power-down, 1 = powered down |
| pll_intmode | output | 1 | Integer mode (fractional modulator bypassed) |
| mode_norm | output | 1 | 1 = consumer on PLL output, 0 = on crystal |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes with lock |
| range_err | output | 1 | One-cycle pulse when a command is refused |
| lock_err | output | 1 | One-cycle pulse on lock timeout |

## Verification
Several properties are checked on every cycle:
- divider writes happen only while the PLL is powered down in integer mode with the consumer on the bypass;
- power-up never coincides with normal mode;
- a switch to normal mode always follows a sample of lock_n=0;
- the three result pulses are mutually exclusive, and each implies the block is idle in the right mode.

The bench covers what needs whole scenarios:
- the exact range bounds;
- the edge-by-edge order of the sequence;
- the poll timing;
- the timeout latency;
- that a refused command or a start during a sequence leaves the divider outputs untouched.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INTM,
      ST_PDN,
      ST_LD0,
      ST_LD1,
      ST_PUP,
      ST_LOCK
   } seq_state_t;
endpackage

// File: rtl/pll_range_chk.sv
module pll_range_chk #(
   parameter int REF_MHZ     = 24,
   parameter int REFDIV_W    = 6,
   parameter int FBDIV_W     = 12,
   parameter int PDIV_W      = 3,
   parameter int VCO_MIN_MHZ = 800,
   parameter int VCO_MAX_MHZ = 3200,
   parameter int OUT_MIN_MHZ = 24,
   parameter int OUT_MAX_MHZ = 3200
) (
   input  logic [REFDIV_W-1:0] refdiv,
   input  logic [FBDIV_W-1:0]  fbdiv,
   input  logic [PDIV_W-1:0]   pd1,
   input  logic [PDIV_W-1:0]   pd2,
   output logic                legal
);
   localparam int PW = FBDIV_W + REFDIV_W + 2*PDIV_W + 16;

   logic [PW-1:0] vco_x_ref;
   logic [PW-1:0] ref_pd;
   logic          nz_ok, vco_ok, out_ok;

   always_comb begin
      vco_x_ref = PW'(REF_MHZ) * PW'(fbdiv);
      ref_pd    = PW'(refdiv) * PW'(pd1) * PW'(pd2);
      nz_ok     = (refdiv != '0) && (pd1 != '0) && (pd2 != '0);
      vco_ok    = (vco_x_ref >= PW'(VCO_MIN_MHZ) * PW'(refdiv)) &&
                  (vco_x_ref <= PW'(VCO_MAX_MHZ) * PW'(refdiv));
      out_ok    = (vco_x_ref >= PW'(OUT_MIN_MHZ) * ref_pd) &&
                  (vco_x_ref <= PW'(OUT_MAX_MHZ) * ref_pd);
      legal     = nz_ok && vco_ok && out_ok;
   end
endmodule

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
   parameter int POLL_CYCLES = 50,
   parameter int LOCK_POLLS  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick,
   output logic last
);
   localparam int PCW = (LOCK_POLLS > 1) ? $clog2(LOCK_POLLS) : 1;

   logic [PCW-1:0] polls;

   generate
      if (POLL_CYCLES < 1) begin : g_bad_poll
         $error("POLL_CYCLES must be at least 1");
      end
      if (LOCK_POLLS < 1) begin : g_bad_limit
         $error("LOCK_POLLS must be at least 1");
      end

      if (POLL_CYCLES == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(POLL_CYCLES);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr) begin
               cnt <= '0;
            end else if (run) begin
               cnt <= (cnt == CW'(POLL_CYCLES-1)) ? '0 : cnt + 1'b1;
            end
         end
         assign tick = run && (cnt == CW'(POLL_CYCLES-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polls <= '0;
      end else if (clr) begin
         polls <= '0;
      end else if (tick) begin
         polls <= polls + 1'b1;
      end
   end

   assign last = tick && (polls == PCW'(LOCK_POLLS-1));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int REF_MHZ     = 24,
   parameter int REFDIV_W    = 6,
   parameter int FBDIV_W     = 12,
   parameter int PDIV_W      = 3,
   parameter int VCO_MIN_MHZ = 800,
   parameter int VCO_MAX_MHZ = 3200,
   parameter int OUT_MIN_MHZ = 24,
   parameter int OUT_MAX_MHZ = 3200,
   parameter int POLL_CYCLES = 50,
   parameter int LOCK_POLLS  = 100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [REFDIV_W-1:0] cfg_refdiv,
   input  logic [FBDIV_W-1:0]  cfg_fbdiv,
   input  logic [PDIV_W-1:0]   cfg_pd1,
   input  logic [PDIV_W-1:0]   cfg_pd2,
   input  logic                lock_n,
   output logic [REFDIV_W-1:0] pll_refdiv,
   output logic [FBDIV_W-1:0]  pll_fbdiv,
   output logic [PDIV_W-1:0]   pll_pd1,
   output logic [PDIV_W-1:0]   pll_pd2,
   output logic                pll_pwrdn,
   output logic                pll_intmode,
   output logic                mode_norm,
   output logic                busy,
   output logic                done,
   output logic                range_err,
   output logic                lock_err
);
   generate
      if (VCO_MIN_MHZ > VCO_MAX_MHZ || OUT_MIN_MHZ > OUT_MAX_MHZ) begin : g_bad_window
         $error("frequency window bounds are reversed");
      end
      if (REFDIV_W < 1 || FBDIV_W < 1 || PDIV_W < 1) begin : g_bad_width
         $error("divider widths must be at least 1");
      end
   endgenerate

   seq_state_t          state;
   logic                cmd_legal;
   logic                tmr_clr, tmr_tick, tmr_last;
   logic [REFDIV_W-1:0] hold_ref;
   logic [FBDIV_W-1:0]  hold_fb;
   logic [PDIV_W-1:0]   hold_pd1, hold_pd2;

   pll_range_chk #(
      .REF_MHZ(REF_MHZ), .REFDIV_W(REFDIV_W), .FBDIV_W(FBDIV_W), .PDIV_W(PDIV_W),
      .VCO_MIN_MHZ(VCO_MIN_MHZ), .VCO_MAX_MHZ(VCO_MAX_MHZ),
      .OUT_MIN_MHZ(OUT_MIN_MHZ), .OUT_MAX_MHZ(OUT_MAX_MHZ)
   ) u_range (
      .refdiv(cfg_refdiv), .fbdiv(cfg_fbdiv), .pd1(cfg_pd1), .pd2(cfg_pd2),
      .legal(cmd_legal)
   );

   assign tmr_clr = (state == ST_PUP);

   pll_poll_timer #(
      .POLL_CYCLES(POLL_CYCLES), .LOCK_POLLS(LOCK_POLLS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
      .run(state == ST_LOCK), .tick(tmr_tick), .last(tmr_last)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         hold_ref    <= '0;
         hold_fb     <= '0;
         hold_pd1    <= '0;
         hold_pd2    <= '0;
         pll_refdiv  <= '0;
         pll_fbdiv   <= '0;
         pll_pd1     <= '0;
         pll_pd2     <= '0;
         pll_pwrdn   <= 1'b1;
         pll_intmode <= 1'b0;
         mode_norm   <= 1'b0;
         done        <= 1'b0;
         range_err   <= 1'b0;
         lock_err    <= 1'b0;
      end else begin
         done      <= 1'b0;
         range_err <= 1'b0;
         lock_err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (cmd_legal) begin
                     hold_ref  <= cfg_refdiv;
                     hold_fb   <= cfg_fbdiv;
                     hold_pd1  <= cfg_pd1;
                     hold_pd2  <= cfg_pd2;
                     mode_norm <= 1'b0;
                     state     <= ST_INTM;
                  end else begin
                     range_err <= 1'b1;
                  end
               end
            end
            ST_INTM: begin
               pll_intmode <= 1'b1;
               state       <= ST_PDN;
            end
            ST_PDN: begin
               pll_pwrdn <= 1'b1;
               state     <= ST_LD0;
            end
            ST_LD0: begin
               pll_pd1   <= hold_pd1;
               pll_fbdiv <= hold_fb;
               state     <= ST_LD1;
            end
            ST_LD1: begin
               pll_pd2    <= hold_pd2;
               pll_refdiv <= hold_ref;
               state      <= ST_PUP;
            end
            ST_PUP: begin
               pll_pwrdn <= 1'b0;
               state     <= ST_LOCK;
            end
            ST_LOCK: begin
               if (tmr_tick) begin
                  if (!lock_n) begin
                     mode_norm <= 1'b1;
                     done      <= 1'b1;
                     state     <= ST_IDLE;
                  end else if (tmr_last) begin
                     lock_err <= 1'b1;
                     state    <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
   parameter int REFDIV_W = 6,
   parameter int FBDIV_W  = 12,
   parameter int PDIV_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lock_n,
   input logic [REFDIV_W-1:0] pll_refdiv,
   input logic [FBDIV_W-1:0]  pll_fbdiv,
   input logic [PDIV_W-1:0]   pll_pd1,
   input logic [PDIV_W-1:0]   pll_pd2,
   input logic                pll_pwrdn,
   input logic                pll_intmode,
   input logic                mode_norm,
   input logic                busy,
   input logic                done,
   input logic                range_err,
   input logic                lock_err
);
   a_r9_load_only_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(pll_fbdiv) || !$stable(pll_pd1) || !$stable(pll_pd2) || !$stable(pll_refdiv))
      |-> (pll_pwrdn && pll_intmode && !mode_norm));

   a_r4_powerup_in_slow: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_pwrdn) |-> !mode_norm);

   a_r6_norm_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_norm) |-> (!$past(lock_n) && !pll_pwrdn && done));

   a_r6_done_idle_norm: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mode_norm && !busy));

   a_r7_timeout_stays_slow: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> (!mode_norm && !busy));

   a_r3_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |-> (!busy && $stable(mode_norm) && $stable(pll_pwrdn)));

   a_r6_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, range_err, lock_err}));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .REFDIV_W(REFDIV_W), .FBDIV_W(FBDIV_W), .PDIV_W(PDIV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_n(lock_n),
   .pll_refdiv(pll_refdiv), .pll_fbdiv(pll_fbdiv),
   .pll_pd1(pll_pd1), .pll_pd2(pll_pd2),
   .pll_pwrdn(pll_pwrdn), .pll_intmode(pll_intmode), .mode_norm(mode_norm),
   .busy(busy), .done(done), .range_err(range_err), .lock_err(lock_err)
);

// File: tb/pll_reprog_seq_tb_top.sv
module pll_reprog_seq_tb_top;
   localparam int POLL  = 4;
   localparam int TOUT  = 5;
   localparam int DLY   = 9;
   // first poll index k (multiple of POLL) whose sample sees lock: k-1 >= DLY
   localparam int LOCK_K    = ((DLY + POLL) / POLL) * POLL;
   localparam int DONE_EDGE = 6 + LOCK_K;
   localparam int TOUT_EDGE = 6 + POLL * TOUT;

   typedef struct packed {
      logic [5:0]  r;
      logic [11:0] f;
      logic [2:0]  p1;
      logic [2:0]  p2;
      logic        ok;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{6'd1, 12'd50,  3'd3, 3'd1, 1'b1},
      '{6'd1, 12'd75,  3'd3, 3'd1, 1'b1},
      '{6'd1, 12'd100, 3'd3, 3'd1, 1'b1},
      '{6'd1, 12'd33,  3'd1, 3'd1, 1'b0},
      '{6'd3, 12'd100, 3'd1, 3'd1, 1'b1},
      '{6'd1, 12'd134, 3'd1, 3'd1, 1'b0},
      '{6'd1, 12'd133, 3'd1, 3'd1, 1'b1},
      '{6'd2, 12'd67,  3'd2, 3'd1, 1'b1},
      '{6'd1, 12'd50,  3'd7, 3'd7, 1'b1},
      '{6'd1, 12'd40,  3'd7, 3'd7, 1'b0},
      '{6'd0, 12'd50,  3'd1, 3'd1, 1'b0},
      '{6'd1, 12'd50,  3'd0, 3'd1, 1'b0},
      '{6'd1, 12'd49,  3'd7, 3'd7, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  cfg_refdiv = '0;
   logic [11:0] cfg_fbdiv = '0;
   logic [2:0]  cfg_pd1 = '0, cfg_pd2 = '0;
   logic        lock_n;
   logic [5:0]  pll_refdiv;
   logic [11:0] pll_fbdiv;
   logic [2:0]  pll_pd1, pll_pd2;
   logic        pll_pwrdn, pll_intmode, mode_norm, busy, done, range_err, lock_err;

   logic never_lock = 1'b0;
   int   lk_cnt = 0;
   int   n_chk = 0, n_bad = 0, cyc = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (pll_pwrdn) lk_cnt <= 0;
      else if (lk_cnt < 1000) lk_cnt <= lk_cnt + 1;
   end
   assign lock_n = pll_pwrdn || never_lock || (lk_cnt < DLY);

   pll_reprog_seq #(.POLL_CYCLES(POLL), .LOCK_POLLS(TOUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_refdiv(cfg_refdiv), .cfg_fbdiv(cfg_fbdiv), .cfg_pd1(cfg_pd1), .cfg_pd2(cfg_pd2),
      .lock_n(lock_n),
      .pll_refdiv(pll_refdiv), .pll_fbdiv(pll_fbdiv), .pll_pd1(pll_pd1), .pll_pd2(pll_pd2),
      .pll_pwrdn(pll_pwrdn), .pll_intmode(pll_intmode), .mode_norm(mode_norm),
      .busy(busy), .done(done), .range_err(range_err), .lock_err(lock_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      while (cyc < 100000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 100000);
      finish_up();
   end

   // drive a command; returns edge number (start edge = 1) of first result pulse
   task automatic run_cmd(input vec_t v, output int edge_n, output int kind);
      @(negedge clk);
      cfg_refdiv = v.r; cfg_fbdiv = v.f; cfg_pd1 = v.p1; cfg_pd2 = v.p2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      edge_n = 1;
      kind = 0;
      for (int i = 0; i < 200; i++) begin
         if (done)      begin kind = 1; break; end
         if (range_err) begin kind = 2; break; end
         if (lock_err)  begin kind = 3; break; end
         @(negedge clk);
         edge_n++;
      end
   endtask

   function automatic int fields();
      return {pll_refdiv, pll_fbdiv, pll_pd1, pll_pd2};
   endfunction

   initial begin
      int   en, kd, snap;
      vec_t good;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!mode_norm && pll_pwrdn && !pll_intmode && fields() == 0, "R1 reset outputs",
            fields(), 0);
      check(!busy && !done && !range_err && !lock_err, "R1 reset flags",
            {busy, done, range_err, lock_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 edge-by-edge order with a legal command
      cfg_refdiv = 6'd1; cfg_fbdiv = 12'd50; cfg_pd1 = 3'd3; cfg_pd2 = 3'd1;
      start = 1'b1;
      @(negedge clk); start = 1'b0;   // after edge 1
      check(busy && !mode_norm && !pll_intmode, "R4 edge1 bypass", {busy, mode_norm, pll_intmode}, 4);
      @(negedge clk);
      check(pll_intmode && pll_pwrdn, "R4 edge2 intmode", pll_intmode, 1);
      @(negedge clk);
      check(pll_pwrdn && pll_fbdiv == 0, "R4 edge3 powerdown", pll_fbdiv, 0);
      @(negedge clk);
      check(pll_fbdiv == 50 && pll_pd1 == 3 && pll_refdiv == 0, "R4 edge4 word0",
            pll_fbdiv, 50);
      @(negedge clk);
      check(pll_refdiv == 1 && pll_pd2 == 1 && pll_pwrdn, "R4 edge5 word1", pll_refdiv, 1);
      @(negedge clk);
      check(!pll_pwrdn && !mode_norm && busy, "R4 edge6 powerup", pll_pwrdn, 0);
      en = 6;
      while (!done && en < 200) begin @(negedge clk); en++; end
      check(en == DONE_EDGE, "R5 lock sampled on poll grid", en, DONE_EDGE);
      check(mode_norm && !busy, "R6 normal mode after lock", mode_norm, 1);
      @(negedge clk);
      check(!done, "R6 done is one cycle", done, 0);

      // Table walk: R2 range decisions, R3 refusals, R6 completions
      good = '{6'd1, 12'd50, 3'd3, 3'd1, 1'b1};
      for (int i = 0; i < NV; i++) begin
         snap = fields();
         run_cmd(VEC[i], en, kd);
         if (VEC[i].ok) begin
            check(kd == 1 && en == DONE_EDGE, "R2 legal command completes", en, DONE_EDGE);
            check(pll_fbdiv == VEC[i].f && pll_refdiv == VEC[i].r &&
                  pll_pd1 == VEC[i].p1 && pll_pd2 == VEC[i].p2 && mode_norm,
                  "R6 fields match command", pll_fbdiv, VEC[i].f);
            good = VEC[i];
         end else begin
            check(kd == 2 && en == 1, "R2 illegal command refused", kd, 2);
            check(fields() == snap && mode_norm && !busy && !pll_pwrdn,
                  "R3 outputs unchanged on refusal", fields(), snap);
            @(negedge clk);
            check(!range_err, "R3 range_err one cycle", range_err, 0);
         end
      end

      // R8 start during busy ignored
      @(negedge clk);
      cfg_refdiv = 6'd1; cfg_fbdiv = 12'd75; cfg_pd1 = 3'd3; cfg_pd2 = 3'd1;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      cfg_refdiv = 6'd2; cfg_fbdiv = 12'd100; cfg_pd1 = 3'd2; cfg_pd2 = 3'd2;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      en = 3;
      while (!done && en < 200) begin @(negedge clk); en++; end
      check(en == DONE_EDGE, "R8 sequence timing unchanged", en, DONE_EDGE);
      check(pll_fbdiv == 75 && pll_refdiv == 1 && pll_pd2 == 1, "R8 first command kept",
            pll_fbdiv, 75);
      @(negedge clk);
      check(!busy && !done, "R8 second start not queued", busy, 0);

      // R7 lock timeout
      never_lock = 1'b1;
      run_cmd('{6'd1, 12'd100, 3'd3, 3'd1, 1'b1}, en, kd);
      check(kd == 3 && en == TOUT_EDGE, "R7 timeout latency", en, TOUT_EDGE);
      check(!mode_norm && !busy, "R7 stays slow after timeout", mode_norm, 0);
      @(negedge clk);
      check(!lock_err && !mode_norm, "R7 lock_err one cycle", lock_err, 0);

      // recovery after timeout
      never_lock = 1'b0;
      run_cmd('{6'd1, 12'd50, 3'd3, 3'd1, 1'b1}, en, kd);
      check(kd == 1 && mode_norm && pll_fbdiv == 50, "R6 recovery after timeout", kd, 1);

      // R3 refusal while parked in slow mode keeps slow mode
      never_lock = 1'b1;
      run_cmd('{6'd1, 12'd75, 3'd3, 3'd1, 1'b1}, en, kd);
      snap = fields();
      run_cmd('{6'd1, 12'd200, 3'd1, 3'd1, 1'b0}, en, kd);
      check(kd == 2 && !mode_norm && fields() == snap, "R3 refusal in slow mode", fields(), snap);

      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule